// File: doc/BRIEF.md
# Stipple and Block-Copy Engine

This block is a small pixel accelerator for an 8-bit-per-pixel framebuffer. A host issues 32-bit register writes, each with an address and a data word. A write to the colour slot (address bit 2 clear) loads a holding register. A write to the command slot (address bit 2 set) starts a pixel operation whose destination pixel index is taken from the address. The `cmd_mode` input picks the operation family. Stipple mode paints up to 32 consecutive pixels under a bit mask. Block mode either fills a run of 1 to 32 pixels or copies such a run from a source index.

The engine drives one single-port synchronous pixel RAM and touches one pixel per cycle. While an operation runs it holds `busy` high and lowers `cmd_ready`, so a new access waits at the port until the current one is finished. Completion is signalled by a one-cycle `done` pulse in the same cycle that `busy` falls. Reads of the register window return zero.

Top module: `pixel_raster_engine`

## Requirements
- R1: After synchronous reset `busy` and `done` are 0, `cmd_ready` is 1, `mem_en` is 0 and `rd_data` is 0.
- R2: An accepted full-word write with address bit 2 equal to 0 loads the data word into the colour register, starts no operation and makes no pixel RAM access.
- R3: An accepted full-word write with address bit 2 equal to 1 starts an operation at destination index (address >> 3) & 0xFFFFF, reduced modulo the pixel RAM size. Destination indices that run past the top of the RAM wrap to 0.
- R4: With `cmd_mode` = 0 (stipple) the data word is a mask. Pixel dest+i receives the low byte of the colour register exactly when mask bit 31-i is 1, and pixels with a clear mask bit are not written. The operation always keeps `busy` high for 32 cycles, even when the mask is zero.
- R5: With `cmd_mode` = 1 (block) the run length is data[28:24] + 1, which spans 1 to 32 pixels, and data bits 31:29 have no effect.
- R6: In block mode a source field data[23:0] equal to 0xFFFFFF is a fill. Each of the len pixels from dest upward receives the colour low byte, one pixel per cycle, and `busy` stays high for len cycles.
- R7: In block mode any other source field copies len pixels from source index data[23:0] (modulo the RAM size) to dest, one pixel at a time in ascending order. Each pixel is read one cycle before it is written, so `busy` stays high for 2*len cycles. An overlapping copy with dest just above src repeats the first source pixel.
- R8: `done` is high for exactly one cycle, in the first cycle after the last pixel access. That is also the first cycle with `busy` low. `cmd_ready` is 0 for as long as `busy` is 1, and an access presented during that time waits and is taken only once the engine is idle.
- R9: Reads (`cmd_write` = 0) return 0 on `rd_data` and change nothing. Writes whose four byte enables are not all set are completed at the port but ignored: the colour register is not changed and no operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host access present |
| cmd_ready | output | 1 | Engine can take an access (low while busy) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_be | input | 4 | Byte enables; only 4'hF writes take effect |
| cmd_mode | input | 1 | 0 = stipple, 1 = block fill/copy |
| cmd_addr | input | ADDR_W | Access address; bit 2 selects colour slot or command slot, bits above 2 give the destination |
| cmd_data | input | 32 | Write data word |
| rd_data | output | 32 | Read data, always zero |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | Pixel RAM enable |
| mem_we | output | 1 | Pixel RAM write enable |
| mem_addr | output | PIX_AW | Pixel RAM address |
| mem_wdata | output | 8 | Pixel RAM write data |
| mem_rdata | input | 8 | Pixel RAM read data, valid one cycle after a read enable |

## Verification
On every cycle the assertions check the following:
- `done` is a lone pulse that never coincides with `busy`.
- The RAM is idle whenever the engine is idle.
- Every copy write directly follows a read.
- Fill writes step through ascending addresses.
- An accepted command always raises `busy`, and a colour load never does.

Only the bench scenarios can show the actual pixel contents and the exact busy durations. These cover masks with sparse or empty bits, fills of 1 and 32 pixels, overlapping and truncated-source copies, and destination wrap. The same applies to stalling behind a running operation and to ignored reads and partial writes.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int WORD_W     = 32;
  localparam int DEST_W     = 20;
  localparam int SRC_W      = 24;
  localparam int LEN_FLD_W  = 5;
  localparam int LEN_W      = LEN_FLD_W + 1;
  localparam int LEN_LSB    = SRC_W;
  localparam int PIX_W      = 8;
  localparam int STIP_SPAN  = WORD_W;
  localparam logic [SRC_W-1:0] FILL_SRC = '1;

  typedef enum logic [1:0] {
    OP_STIP = 2'd0,
    OP_FILL = 2'd1,
    OP_COPY = 2'd2
  } op_kind_t;

  typedef struct packed {
    op_kind_t            kind;
    logic [DEST_W-1:0]   dest;
    logic [SRC_W-1:0]    src;
    logic [LEN_W-1:0]    len;
    logic [WORD_W-1:0]   mask;
  } raster_cmd_t;
endpackage

// File: rtl/raster_cmd_decode.sv
module raster_cmd_decode
  import raster_pkg::*;
#(
  parameter int ADDR_W = 23
) (
  input  logic              acc_write,
  input  logic [3:0]        acc_be,
  input  logic              acc_mode,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [WORD_W-1:0] acc_data,
  output logic              is_colour,
  output logic              is_exec,
  output raster_cmd_t       cmd
);
  localparam int DEST_LSB = 3;
  localparam int DEST_MSB = DEST_LSB + DEST_W - 1;

  logic full_write;
  logic [SRC_W-1:0] src_fld;
  logic unused_addr;

  assign full_write = acc_write && (&acc_be);
  assign is_colour  = full_write && !acc_addr[2];
  assign is_exec    = full_write &&  acc_addr[2];
  assign src_fld    = acc_data[SRC_W-1:0];
  assign unused_addr = ^acc_addr[1:0];

  always_comb begin
    cmd.dest = acc_addr[DEST_MSB:DEST_LSB];
    cmd.src  = src_fld;
    cmd.len  = LEN_W'(acc_data[LEN_LSB +: LEN_FLD_W]) + LEN_W'(1);
    cmd.mask = acc_data;
    if (!acc_mode) begin
      cmd.kind = OP_STIP;
    end else if (src_fld == FILL_SRC) begin
      cmd.kind = OP_FILL;
    end else begin
      cmd.kind = OP_COPY;
    end
  end
endmodule

// File: rtl/raster_colour_reg.sv
module raster_colour_reg
  import raster_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] din,
  output logic [PIX_W-1:0]  colour
);
  logic [WORD_W-1:0] hold_q;
  logic unused_hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (load) begin
      hold_q <= din;
    end
  end

  assign colour      = hold_q[PIX_W-1:0];
  assign unused_hold = ^hold_q[WORD_W-1:PIX_W];
endmodule

// File: rtl/raster_seq.sv
module raster_seq
  import raster_pkg::*;
#(
  parameter int PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  raster_cmd_t       cmd,
  input  logic [PIX_W-1:0]  colour,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata,
  input  logic [PIX_W-1:0]  mem_rdata
);
  op_kind_t          kind_q;
  logic [PIX_AW-1:0] dst_q;
  logic [PIX_AW-1:0] src_q;
  logic [WORD_W-1:0] mask_q;
  logic [LEN_W-1:0]  left_q;
  logic              wr_phase_q;
  logic [PIX_W-1:0]  col_q;
  logic              last_step;
  logic              pix_step;

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = dst_q;
    mem_wdata = col_q;
    pix_step  = 1'b0;
    if (busy) begin
      case (kind_q)
        OP_STIP: begin
          mem_en   = mask_q[WORD_W-1];
          mem_we   = mask_q[WORD_W-1];
          pix_step = 1'b1;
        end
        OP_FILL: begin
          mem_en   = 1'b1;
          mem_we   = 1'b1;
          pix_step = 1'b1;
        end
        default: begin
          mem_en = 1'b1;
          if (wr_phase_q) begin
            mem_we    = 1'b1;
            mem_wdata = mem_rdata;
            pix_step  = 1'b1;
          end else begin
            mem_addr = src_q;
          end
        end
      endcase
    end
  end

  assign last_step = pix_step && (left_q == LEN_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      kind_q     <= OP_STIP;
      dst_q      <= '0;
      src_q      <= '0;
      mask_q     <= '0;
      left_q     <= '0;
      wr_phase_q <= 1'b0;
      col_q      <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy       <= 1'b1;
          kind_q     <= cmd.kind;
          dst_q      <= PIX_AW'(cmd.dest);
          src_q      <= PIX_AW'(cmd.src);
          mask_q     <= cmd.mask;
          left_q     <= (cmd.kind == OP_STIP) ? LEN_W'(STIP_SPAN) : cmd.len;
          wr_phase_q <= 1'b0;
          col_q      <= colour;
        end
      end else begin
        if (kind_q == OP_COPY) begin
          wr_phase_q <= !wr_phase_q;
          if (!wr_phase_q) begin
            src_q <= src_q + PIX_AW'(1);
          end
        end
        if (pix_step) begin
          dst_q  <= dst_q + PIX_AW'(1);
          mask_q <= mask_q << 1;
          left_q <= left_q - LEN_W'(1);
        end
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_en);

  // R7
  copy_rd_first_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && kind_q == OP_COPY && mem_we) |-> $past(mem_en && !mem_we));

  // R6
  fill_ascend_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && kind_q == OP_FILL && mem_we && $past(busy && mem_we))
      |-> (mem_addr == PIX_AW'($past(mem_addr) + PIX_AW'(1))));
endmodule

// File: rtl/pixel_raster_engine.sv
module pixel_raster_engine
  import raster_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int PIX_AW = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [3:0]        cmd_be,
  input  logic              cmd_mode,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [31:0]       cmd_data,
  output logic [31:0]       rd_data,
  output logic              busy,
  output logic              done,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PIX_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  logic             accept;
  logic             is_colour;
  logic             is_exec;
  raster_cmd_t      dec_cmd;
  logic [PIX_W-1:0] colour;

  assign cmd_ready = !busy;
  assign accept    = cmd_valid && cmd_ready;
  assign rd_data   = '0;

  raster_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
    .acc_write (cmd_write),
    .acc_be    (cmd_be),
    .acc_mode  (cmd_mode),
    .acc_addr  (cmd_addr),
    .acc_data  (cmd_data),
    .is_colour (is_colour),
    .is_exec   (is_exec),
    .cmd       (dec_cmd)
  );

  raster_colour_reg u_colour (
    .clk    (clk),
    .rst    (rst),
    .load   (accept && is_colour),
    .din    (cmd_data),
    .colour (colour)
  );

  raster_seq #(.PIX_AW(PIX_AW)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start     (accept && is_exec),
    .cmd       (dec_cmd),
    .colour    (colour),
    .busy      (busy),
    .done      (done),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  // R3
  exec_starts_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && is_exec) |=> busy);

  // R2
  colour_no_op_chk: assert property (@(posedge clk) disable iff (rst)
    (accept && is_colour) |=> !busy);
endmodule

// File: tb/test_pixel_raster_engine.sv
module test_pixel_raster_engine;
  localparam int AW   = 23;
  localparam int PW   = 12;
  localparam int NPIX = 1 << PW;
  localparam int NVEC = 10;

  // {tag[3:0], mode, dest[19:0], data[31:0], colour[31:0]}
  localparam logic [88:0] VEC [NVEC] = '{
    {4'd4, 1'b0, 20'd16,            32'h8000_0001, 32'h0000_005A},
    {4'd4, 1'b0, 20'd100,           32'hF0F0_1234, 32'h0000_01C3},
    {4'd5, 1'b1, 20'd200,           32'hFFFF_FFFF, 32'h0000_0077},
    {4'd6, 1'b1, 20'd300,           32'h00FF_FFFF, 32'h0000_00AB},
    {4'd7, 1'b1, 20'd400,           32'h0700_00C8, 32'h0000_0000},
    {4'd7, 1'b1, 20'd17,            32'h0400_0010, 32'h0000_0000},
    {4'd7, 1'b1, 20'd500,           32'h0210_0ABC, 32'h0000_0000},
    {4'd3, 1'b0, 20'd16382,         32'hE000_0000, 32'h0000_0011},
    {4'd4, 1'b0, 20'd1000,          32'h0000_0000, 32'h0000_00EE},
    {4'd6, 1'b1, 20'd1100,          32'h1FFF_FFFF, 32'h0000_0042}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0, cmd_mode = 1'b0;
  logic [3:0] cmd_be = 4'h0;
  logic [AW-1:0] cmd_addr = '0;
  logic [31:0] cmd_data = '0;
  logic cmd_ready, busy, done, mem_en, mem_we;
  logic [31:0] rd_data;
  logic [PW-1:0] mem_addr;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;

  logic [7:0] ram   [NPIX];
  logic [7:0] model [NPIX];
  int mem_touch = 0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pixel_raster_engine #(.ADDR_W(AW), .PIX_AW(PW)) i_pixel_raster_engine (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_be(cmd_be), .cmd_mode(cmd_mode),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rd_data(rd_data),
    .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      mem_rdata <= ram[mem_addr];
      mem_touch <= mem_touch + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exec_addr(input logic [19:0] dest);
    return {dest, 3'b100};
  endfunction

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic issue(input logic wr, input logic [AW-1:0] addr,
                       input logic [31:0] data, input logic [3:0] be,
                       input logic mode);
    @(negedge clk);
    cmd_write = wr; cmd_addr = addr; cmd_data = data; cmd_be = be;
    cmd_mode = mode; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
  endtask

  task automatic run_op(input string req, input int exp_cycles);
    int n = 0;
    while (busy && n < 200) begin
      n++;
      @(negedge clk);
    end
    check(n == exp_cycles, req, "busy cycles", n, exp_cycles);
    check(done == 1'b1, "R8", "done at busy fall", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", done, 0);
  endtask

  task automatic compare_mem(input string req);
    int bad = 0;
    for (int i = 0; i < NPIX; i++) if (ram[i] !== model[i]) bad++;
    check(bad == 0, req, "pixel mismatches", bad, 0);
  endtask

  task automatic model_op(input logic mode, input logic [19:0] dest,
                          input logic [31:0] data, input logic [7:0] col,
                          output int cycles);
    int d = int'(dest) % NPIX;
    int len = int'(data[28:24]) + 1;
    if (!mode) begin
      for (int i = 0; i < 32; i++)
        if (data[31-i]) model[(d + i) % NPIX] = col;
      cycles = 32;
    end else if (data[23:0] == 24'hFFFFFF) begin
      for (int i = 0; i < len; i++) model[(d + i) % NPIX] = col;
      cycles = len;
    end else begin
      int s = int'(data[23:0]) % NPIX;
      for (int i = 0; i < len; i++)
        model[(d + i) % NPIX] = model[(s + i) % NPIX];
      cycles = 2 * len;
    end
  endtask

  task automatic idle_watch(input string req, input int touch0);
    repeat (3) begin
      @(negedge clk);
      check(busy == 1'b0, req, "busy stays low", busy, 0);
    end
    check(mem_touch == touch0, req, "no RAM access", mem_touch, touch0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int cyc;
    int t0;
    for (int i = 0; i < NPIX; i++) begin
      ram[i]   = 8'((i * 7) ^ (i >> 4));
      model[i] = 8'((i * 7) ^ (i >> 4));
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy", busy, 0);
    check(done == 1'b0, "R1", "done", done, 0);
    check(cmd_ready == 1'b1, "R1", "ready", cmd_ready, 1);
    check(mem_en == 1'b0, "R1", "mem_en", mem_en, 0);
    check(rd_data == 32'h0, "R1", "rd_data", rd_data, 0);

    // R2 colour load starts nothing
    t0 = mem_touch;
    issue(1'b1, 23'h000100, 32'h1234_56A5, 4'hF, 1'b1);
    idle_watch("R2", t0);

    // vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [88:0] e = VEC[v];
      string req = tag_name(e[88:85]);
      issue(1'b1, 23'h000000, e[31:0], 4'hF, 1'b0);
      issue(1'b1, exec_addr(e[83:64]), e[63:32], 4'hF, e[84]);
      model_op(e[84], e[83:64], e[63:32], e[7:0], cyc);
      run_op(req, cyc);
      compare_mem(req);
    end

    // R8 stall behind a running fill
    issue(1'b1, 23'h000008, 32'h0000_003C, 4'hF, 1'b0);
    issue(1'b1, exec_addr(20'd600), 32'h0FFF_FFFF, 4'hF, 1'b1);
    model_op(1'b1, 20'd600, 32'h0FFF_FFFF, 8'h3C, cyc);
    cmd_write = 1'b1; cmd_addr = exec_addr(20'd700); cmd_data = 32'hFFFF_0000;
    cmd_be = 4'hF; cmd_mode = 1'b0; cmd_valid = 1'b1;
    check(cmd_ready == 1'b0, "R8", "ready while busy", cmd_ready, 0);
    begin
      int n = 0;
      while (!cmd_ready && n < 200) begin
        n++;
        @(negedge clk);
      end
      check(n == 16, "R8", "stall cycles", n, 16);
    end
    @(negedge clk);
    cmd_valid = 1'b0; cmd_write = 1'b0;
    model_op(1'b0, 20'd700, 32'hFFFF_0000, 8'h3C, cyc);
    run_op("R8", cyc);
    compare_mem("R8");

    // R9 read returns zero and does nothing
    t0 = mem_touch;
    issue(1'b0, exec_addr(20'd800), 32'h00FF_FFFF, 4'hF, 1'b1);
    check(rd_data == 32'h0, "R9", "read data", rd_data, 0);
    idle_watch("R9", t0);

    // R9 partial write to command slot ignored
    t0 = mem_touch;
    issue(1'b1, exec_addr(20'd800), 32'h00FF_FFFF, 4'h7, 1'b1);
    idle_watch("R9", t0);

    // R9 partial write to colour slot ignored: colour stays 0x3C
    issue(1'b1, 23'h000000, 32'h0000_00EE, 4'hE, 1'b0);
    issue(1'b1, exec_addr(20'd900), 32'h8000_0000, 4'hF, 1'b0);
    model_op(1'b0, 20'd900, 32'h8000_0000, 8'h3C, cyc);
    run_op("R9", cyc);
    compare_mem("R9");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule